// File: doc/BRIEF.md
# Single-Bus Microcoded Processor Datapath

This block is the data side of a microcoded processor in which every transfer between units crosses one shared 32-bit bus. An external microcode sequencer supplies a control word each cycle. The control word picks the one unit that drives the bus and the latches that capture the bus at the next clock edge. The units on the bus are a 33-entry register array, the memory port, the immediate generator and the ALU. The latches are the instruction latch, the ALU operand latches A and B, and the memory address latch. The program counter is not a separate register: it is entry 32 of the register array. Software-visible instructions are interpreted by sequencing these transfers over several cycles.

The bus is a multiplexer tree, not a set of tri-state drivers. A small control module encodes the four drive enables into a source select. The register array and the memory each have a chip enable. With the chip enable low, the unit neither reads nor writes. The datapath reports three things back to the sequencer: the opcode field of the instruction latch, a zero flag from the ALU, and a memory-busy status.

Top module: `sbus_cpu_datapath`

## Requirements
- R1: With exactly one of enReg, enMem, enImm or enAlu high, busValue equals that unit's output in the same cycle. With none high, busValue is zero. The controller keeps at most one of them high in any cycle.
- R2: The latches IR, A, B and MA take busValue at a rising clock edge only when ldIr, ldA, ldB or ldMa respectively is high. Otherwise they hold their value.
- R3: The register array has 33 entries. An entry takes busValue at a clock edge only when both regEn and regWr are high. The array's output is zero while regEn is low. Entry 0 always reads zero, and writes to it are dropped.
- R4: regSel picks the array entry as follows: 0 = IR[11:7], 1 = IR[19:15], 2 = IR[24:20], 3 = entry 32 (the program counter), 4 = entry 1 (the return address).
- R5: aluOp selects the ALU operation on A and B, and the shift amount is B[4:0]. The codes are:
  - 0: A+B
  - 1: A-B
  - 2: AND
  - 3: OR
  - 4: XOR
  - 5: shift left
  - 6: logical shift right
  - 7: arithmetic shift right
  - 8: signed A<B, giving 1 or 0
  - 9: A
  - 10: A+4
  - any other code: 0
- R6: zero is high exactly when the ALU result is zero. It is combinational on the current A, B and aluOp.
- R7: immSel picks the immediate built from IR, and sign extension is from IR[31]. The formats are:
  - 0: IR[31:20]
  - 1: {IR[31:25],IR[11:7]}
  - 2: {IR[31],IR[7],IR[30:25],IR[11:8],0}
  - 3: {IR[31:12],12 zeros}
  - 4: {IR[31],IR[19:12],IR[20],IR[30:21],0}
  - any other code: 0
- R8: Memory holds 64 words, and the word index is MA[7:2]. The memory output drives the bus with enMem. That output is the addressed word while memEn is high and zero while memEn is low.
- R9: An access is a cycle with memEn high and memBusy low. After each access, memBusy is high for exactly 2 cycles and then falls. A cycle with memEn high while memBusy is high does not start a new access.
- R10: A memory word takes busValue only in an access cycle with memWr high. A write with memEn low, or while memBusy is high, leaves memory unchanged.
- R11: opcode always equals IR[6:0].
- R12: After reset:
  - IR, A, B and MA are zero.
  - Every register entry is zero.
  - memBusy is low.
  - Memory word i holds i*32'h9E3779B1, truncated to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| ldIr | input | 1 | Instruction latch load |
| ldA | input | 1 | Operand A latch load |
| ldB | input | 1 | Operand B latch load |
| ldMa | input | 1 | Memory address latch load |
| regSel | input | 3 | Register array index source |
| regEn | input | 1 | Register array chip enable |
| regWr | input | 1 | Register array write |
| memEn | input | 1 | Memory chip enable |
| memWr | input | 1 | Memory write |
| immSel | input | 3 | Immediate format select |
| aluOp | input | 4 | ALU operation |
| enReg | input | 1 | Register array drives bus |
| enMem | input | 1 | Memory drives bus |
| enImm | input | 1 | Immediate drives bus |
| enAlu | input | 1 | ALU drives bus |
| opcode | output | 7 | IR[6:0] to the sequencer |
| zero | output | 1 | ALU result is zero |
| memBusy | output | 1 | Memory busy after an access |
| busValue | output | 32 | Current shared bus value |

## Verification
The checks assume that the controller never raises more than one drive enable in a cycle. When two are raised, the multiplexer picks one by a fixed priority, and that choice is not part of the contract. The stimulus builds every control word with a single drive enable, or with none when the bus is idle. Operand values are never forced in from outside: each one is brought in through the memory fill pattern, the A+4 operation or an idle bus. This keeps every bench cycle a control word that a real microprogram could issue. Memory accesses that are meant to take effect are issued only after busy has fallen. Accesses made while busy is high are issued on purpose, to show that they are dropped.

// File: rtl/sbus_pkg.sv
`timescale 1ns/1ps
package sbus_pkg;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_REG  = 3'd1,
    SRC_MEM  = 3'd2,
    SRC_IMM  = 3'd3,
    SRC_ALU  = 3'd4
  } bus_src_e;

  typedef enum logic [2:0] {
    IDX_RD  = 3'd0,
    IDX_RS1 = 3'd1,
    IDX_RS2 = 3'd2,
    IDX_PC  = 3'd3,
    IDX_RA  = 3'd4
  } reg_sel_e;

  typedef enum logic [2:0] {
    IMM_I = 3'd0,
    IMM_S = 3'd1,
    IMM_B = 3'd2,
    IMM_U = 3'd3,
    IMM_J = 3'd4
  } imm_sel_e;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_AND  = 4'd2,
    ALU_OR   = 4'd3,
    ALU_XOR  = 4'd4,
    ALU_SLL  = 4'd5,
    ALU_SRL  = 4'd6,
    ALU_SRA  = 4'd7,
    ALU_SLT  = 4'd8,
    ALU_CPA  = 4'd9,
    ALU_INC4 = 4'd10
  } alu_op_e;

  // Strobes from the control decoder to the datapath and memory
  typedef struct packed {
    logic     ldIr;
    logic     ldA;
    logic     ldB;
    logic     ldMa;
    bus_src_e busSrc;
    logic     regRead;
    logic     regWrite;
    logic     memEnable;
    logic     memWrite;
    reg_sel_e regSel;
    imm_sel_e immSel;
    alu_op_e  aluOp;
  } strobes_t;

endpackage

// File: rtl/sbus_ctrl.sv
`timescale 1ns/1ps
module sbus_ctrl
  import sbus_pkg::*;
(
  input  logic       ldIr,
  input  logic       ldA,
  input  logic       ldB,
  input  logic       ldMa,
  input  logic [2:0] regSel,
  input  logic       regEn,
  input  logic       regWr,
  input  logic       memEn,
  input  logic       memWr,
  input  logic [2:0] immSel,
  input  logic [3:0] aluOp,
  input  logic       enReg,
  input  logic       enMem,
  input  logic       enImm,
  input  logic       enAlu,
  output strobes_t   stb
);

  // Encode the drive enables into one mux select (fixed priority if misused)
  bus_src_e busSrc;
  always_comb begin
    if (enReg)      busSrc = SRC_REG;
    else if (enMem) busSrc = SRC_MEM;
    else if (enImm) busSrc = SRC_IMM;
    else if (enAlu) busSrc = SRC_ALU;
    else            busSrc = SRC_NONE;
  end

  always_comb begin
    stb.ldIr      = ldIr;
    stb.ldA       = ldA;
    stb.ldB       = ldB;
    stb.ldMa      = ldMa;
    stb.busSrc    = busSrc;
    stb.regRead   = regEn;
    stb.regWrite  = regEn & regWr;
    stb.memEnable = memEn;
    stb.memWrite  = memEn & memWr;
    stb.regSel    = reg_sel_e'(regSel);
    stb.immSel    = imm_sel_e'(immSel);
    stb.aluOp     = alu_op_e'(aluOp);
  end

endmodule

// File: rtl/sbus_datapath.sv
`timescale 1ns/1ps
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_GPR = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        stb,
  input  logic [XLEN-1:0] memData,
  output logic [XLEN-1:0] busValue,
  output logic [XLEN-1:0] maAddr,
  output logic [6:0]      opcode,
  output logic            zero
);

  localparam int NUM_ENT = NUM_GPR + 1;
  localparam int RA_W    = $clog2(NUM_ENT);
  localparam int SH_W    = $clog2(XLEN);

  logic [XLEN-1:0] ir, opA, opB, ma;
  logic [XLEN-1:0] rf [NUM_ENT];
  logic [RA_W-1:0] regIdx;
  logic [XLEN-1:0] regData, immVal, aluRes;

  // Register index source
  always_comb begin
    unique case (stb.regSel)
      IDX_RD:  regIdx = RA_W'(ir[11:7]);
      IDX_RS1: regIdx = RA_W'(ir[19:15]);
      IDX_RS2: regIdx = RA_W'(ir[24:20]);
      IDX_PC:  regIdx = RA_W'(NUM_GPR);
      IDX_RA:  regIdx = RA_W'(1);
      default: regIdx = '0;
    endcase
  end

  assign regData = (stb.regRead && regIdx != '0) ? rf[regIdx] : '0;

  // Immediate generator
  always_comb begin
    unique case (stb.immSel)
      IMM_I:   immVal = {{20{ir[31]}}, ir[31:20]};
      IMM_S:   immVal = {{20{ir[31]}}, ir[31:25], ir[11:7]};
      IMM_B:   immVal = {{19{ir[31]}}, ir[31], ir[7], ir[30:25], ir[11:8], 1'b0};
      IMM_U:   immVal = {ir[31:12], 12'b0};
      IMM_J:   immVal = {{11{ir[31]}}, ir[31], ir[19:12], ir[20], ir[30:21], 1'b0};
      default: immVal = '0;
    endcase
  end

  // ALU
  always_comb begin
    unique case (stb.aluOp)
      ALU_ADD:  aluRes = opA + opB;
      ALU_SUB:  aluRes = opA - opB;
      ALU_AND:  aluRes = opA & opB;
      ALU_OR:   aluRes = opA | opB;
      ALU_XOR:  aluRes = opA ^ opB;
      ALU_SLL:  aluRes = opA << opB[SH_W-1:0];
      ALU_SRL:  aluRes = opA >> opB[SH_W-1:0];
      ALU_SRA:  aluRes = $signed(opA) >>> opB[SH_W-1:0];
      ALU_SLT:  aluRes = XLEN'($signed(opA) < $signed(opB));
      ALU_CPA:  aluRes = opA;
      ALU_INC4: aluRes = opA + XLEN'(4);
      default:  aluRes = '0;
    endcase
  end

  assign zero = (aluRes == '0);

  // Shared bus: N:1 mux on the encoded source
  always_comb begin
    unique case (stb.busSrc)
      SRC_REG: busValue = regData;
      SRC_MEM: busValue = memData;
      SRC_IMM: busValue = immVal;
      SRC_ALU: busValue = aluRes;
      default: busValue = '0;
    endcase
  end

  // Latches
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ir  <= '0;
      opA <= '0;
      opB <= '0;
      ma  <= '0;
    end else begin
      if (stb.ldIr) ir  <= busValue;
      if (stb.ldA)  opA <= busValue;
      if (stb.ldB)  opB <= busValue;
      if (stb.ldMa) ma  <= busValue;
    end
  end

  // Register array, program counter as the last entry
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENT; i++) rf[i] <= '0;
    end else if (stb.regWrite && regIdx != '0) begin
      rf[regIdx] <= busValue;
    end
  end

  assign maAddr = ma;
  assign opcode = ir[6:0];

endmodule

// File: rtl/sbus_mem.sv
`timescale 1ns/1ps
module sbus_mem #(
  parameter int          XLEN        = 32,
  parameter int          MEM_WORDS   = 64,
  parameter int          BUSY_CYCLES = 2,
  parameter logic [31:0] FILL_MULT   = 32'h9E3779B1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         memEnable,
  input  logic                         memWrite,
  input  logic [$clog2(MEM_WORDS)-1:0] wordIdx,
  input  logic [XLEN-1:0]              wrData,
  output logic [XLEN-1:0]              rdData,
  output logic                         busy
);

  localparam int CNT_W = (BUSY_CYCLES > 0) ? $clog2(BUSY_CYCLES + 1) : 1;

  logic [XLEN-1:0]  mem [MEM_WORDS];
  logic [CNT_W-1:0] busyCnt;
  logic             access;

  assign busy   = (busyCnt != '0);
  assign access = memEnable && !busy;
  assign rdData = memEnable ? mem[wordIdx] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (access) begin
      busyCnt <= CNT_W'(BUSY_CYCLES);
    end else if (busy) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= XLEN'(FILL_MULT * 32'(i));
    end else if (access && memWrite) begin
      mem[wordIdx] <= wrData;
    end
  end

endmodule

// File: rtl/sbus_cpu_datapath.sv
`timescale 1ns/1ps
module sbus_cpu_datapath
  import sbus_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int NUM_GPR     = 32,
  parameter int MEM_WORDS   = 64,
  parameter int BUSY_CYCLES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ldIr,
  input  logic            ldA,
  input  logic            ldB,
  input  logic            ldMa,
  input  logic [2:0]      regSel,
  input  logic            regEn,
  input  logic            regWr,
  input  logic            memEn,
  input  logic            memWr,
  input  logic [2:0]      immSel,
  input  logic [3:0]      aluOp,
  input  logic            enReg,
  input  logic            enMem,
  input  logic            enImm,
  input  logic            enAlu,
  output logic [6:0]      opcode,
  output logic            zero,
  output logic            memBusy,
  output logic [XLEN-1:0] busValue
);

  localparam int MEM_AW = $clog2(MEM_WORDS);

  strobes_t        stb;
  logic [XLEN-1:0] maAddr, memData;
  logic            unusedMaBits;

  assign unusedMaBits = ^{maAddr[1:0], maAddr[XLEN-1:MEM_AW+2]};

  sbus_ctrl u_ctrl (
    .ldIr(ldIr), .ldA(ldA), .ldB(ldB), .ldMa(ldMa),
    .regSel(regSel), .regEn(regEn), .regWr(regWr),
    .memEn(memEn), .memWr(memWr), .immSel(immSel), .aluOp(aluOp),
    .enReg(enReg), .enMem(enMem), .enImm(enImm), .enAlu(enAlu),
    .stb(stb)
  );

  sbus_datapath #(.XLEN(XLEN), .NUM_GPR(NUM_GPR)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .memData(memData),
    .busValue(busValue), .maAddr(maAddr), .opcode(opcode), .zero(zero)
  );

  sbus_mem #(.XLEN(XLEN), .MEM_WORDS(MEM_WORDS), .BUSY_CYCLES(BUSY_CYCLES)) u_mem (
    .clk(clk), .rstN(rstN), .memEnable(stb.memEnable), .memWrite(stb.memWrite),
    .wordIdx(maAddr[MEM_AW+1:2]), .wrData(busValue), .rdData(memData), .busy(memBusy)
  );

endmodule

// File: rtl/sbus_cpu_datapath_chk.sv
`timescale 1ns/1ps
module sbus_cpu_datapath_chk (
  input logic        clk,
  input logic        rstN,
  input logic        ldIr,
  input logic        memEn,
  input logic        enReg,
  input logic        enMem,
  input logic        enImm,
  input logic        enAlu,
  input logic [6:0]  opcode,
  input logic        zero,
  input logic        memBusy,
  input logic [31:0] busValue
);

  assert_one_driver_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({enReg, enMem, enImm, enAlu}));

  assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(enReg || enMem || enImm || enAlu) |-> busValue == 32'd0);

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enAlu && !enReg && !enMem && !enImm) |-> (zero == (busValue == 32'd0)));

  assert_ir_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ldIr |=> $stable(opcode));

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memBusy) |=> memBusy);

  assert_busy_origin_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memBusy) |-> $past(memEn));

endmodule

bind sbus_cpu_datapath sbus_cpu_datapath_chk u_chk (.*);

// File: tb/sim_sbus_cpu_datapath.sv
`timescale 1ns/1ps
module sim_sbus_cpu_datapath;

  typedef struct packed {
    logic       ldIr, ldA, ldB, ldMa;
    logic [2:0] regSel;
    logic       regEn, regWr, memEn, memWr;
    logic [2:0] immSel;
    logic [3:0] aluOp;
    logic       enReg, enMem, enImm, enAlu;
  } ctrl_t;

  typedef struct packed {
    logic [3:0]  op;
    logic        ldA;
    logic        ldB;
    logic [31:0] bus;
    logic        z;
  } row_t;

  // A=3C6EF362, B=9E3779B1 at the start (R5, R6; R2 hold between rows)
  localparam int NROW = 17;
  localparam row_t TBL [NROW] = '{
    '{4'd0,  1'b0, 1'b0, 32'hDAA66D13, 1'b0},
    '{4'd1,  1'b0, 1'b0, 32'h9E3779B1, 1'b0},
    '{4'd2,  1'b0, 1'b0, 32'h1C267120, 1'b0},
    '{4'd3,  1'b0, 1'b0, 32'hBE7FFBF3, 1'b0},
    '{4'd4,  1'b0, 1'b0, 32'hA2598AD3, 1'b0},
    '{4'd5,  1'b0, 1'b0, 32'hE6C40000, 1'b0},
    '{4'd6,  1'b0, 1'b0, 32'h00001E37, 1'b0},
    '{4'd7,  1'b0, 1'b0, 32'h00001E37, 1'b0},
    '{4'd8,  1'b0, 1'b0, 32'h00000000, 1'b1},
    '{4'd9,  1'b0, 1'b0, 32'h3C6EF362, 1'b0},
    '{4'd10, 1'b0, 1'b0, 32'h3C6EF366, 1'b0},
    '{4'd1,  1'b1, 1'b0, 32'h9E3779B1, 1'b0},
    '{4'd7,  1'b0, 1'b0, 32'hFFFFCF1B, 1'b0},
    '{4'd1,  1'b0, 1'b0, 32'h00000000, 1'b1},
    '{4'd10, 1'b0, 1'b1, 32'h9E3779B5, 1'b0},
    '{4'd8,  1'b0, 1'b0, 32'h00000001, 1'b0},
    '{4'd15, 1'b0, 1'b0, 32'h00000000, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldIr = 0, ldA = 0, ldB = 0, ldMa = 0;
  logic [2:0]  regSel = 0;
  logic        regEn = 0, regWr = 0, memEn = 0, memWr = 0;
  logic [2:0]  immSel = 0;
  logic [3:0]  aluOp = 0;
  logic        enReg = 0, enMem = 0, enImm = 0, enAlu = 0;
  logic [6:0]  opcode;
  logic        zero, memBusy;
  logic [31:0] busValue;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sbus_cpu_datapath u0 (
    .clk(clk), .rstN(rstN), .ldIr(ldIr), .ldA(ldA), .ldB(ldB), .ldMa(ldMa),
    .regSel(regSel), .regEn(regEn), .regWr(regWr), .memEn(memEn), .memWr(memWr),
    .immSel(immSel), .aluOp(aluOp), .enReg(enReg), .enMem(enMem), .enImm(enImm),
    .enAlu(enAlu), .opcode(opcode), .zero(zero), .memBusy(memBusy), .busValue(busValue)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Apply a control word at the falling edge, then settle before sampling
  task automatic go(input ctrl_t c);
    @(negedge clk);
    ldIr = c.ldIr; ldA = c.ldA; ldB = c.ldB; ldMa = c.ldMa;
    regSel = c.regSel; regEn = c.regEn; regWr = c.regWr;
    memEn = c.memEn; memWr = c.memWr; immSel = c.immSel; aluOp = c.aluOp;
    enReg = c.enReg; enMem = c.enMem; enImm = c.enImm; enAlu = c.enAlu;
    #5;
  endtask

  function automatic ctrl_t idleC();
    ctrl_t c = '0;
    return c;
  endfunction

  function automatic ctrl_t aluC(input logic [3:0] op);
    ctrl_t c = '0;
    c.enAlu = 1'b1; c.aluOp = op;
    return c;
  endfunction

  function automatic ctrl_t memRdC();
    ctrl_t c = '0;
    c.enMem = 1'b1; c.memEn = 1'b1;
    return c;
  endfunction

  function automatic ctrl_t regRdC(input logic [2:0] sel);
    ctrl_t c = '0;
    c.enReg = 1'b1; c.regEn = 1'b1; c.regSel = sel;
    return c;
  endfunction

  function automatic ctrl_t regWrC(input logic [3:0] op, input logic [2:0] sel);
    ctrl_t c = aluC(op);
    c.regEn = 1'b1; c.regWr = 1'b1; c.regSel = sel;
    return c;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    ctrl_t c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #5;
    // Reset state
    chk("R12", "opcode after reset", 32'(opcode), 32'h0);
    chk("R12", "busy after reset", 32'(memBusy), 32'h0);
    chk("R1", "idle bus", busValue, 32'h0);
    go(regRdC(3'd3));
    chk("R12", "pc after reset", busValue, 32'h0);
    go(aluC(4'd9));
    chk("R12", "A after reset", busValue, 32'h0);
    chk("R6", "zero with A=0", 32'(zero), 32'h1);

    // Build MA=12 from A+4 steps
    c = aluC(4'd10); c.ldA = 1; go(c);
    chk("R5", "A+4 from 0", busValue, 32'h4);
    chk("R6", "zero clear", 32'(zero), 32'h0);
    c = aluC(4'd10); c.ldA = 1; go(c);
    chk("R2", "A loaded", busValue, 32'h8);
    c = aluC(4'd10); c.ldMa = 1; go(c);
    chk("R2", "A held", busValue, 32'hC);
    c = memRdC(); c.memEn = 0; go(c);
    chk("R8", "memory disabled reads zero", busValue, 32'h0);
    c = memRdC(); c.ldIr = 1; go(c);
    chk("R8", "word 3 fill", busValue, 32'hDAA66D13);
    go(idleC());
    chk("R11", "opcode from IR", 32'(opcode), 32'h13);
    chk("R9", "busy first cycle", 32'(memBusy), 32'h1);

    // Immediates
    c = '0; c.enImm = 1; c.immSel = 3'd0; go(c);
    chk("R7", "I immediate", busValue, 32'hFFFFFDAA);
    chk("R9", "busy second cycle", 32'(memBusy), 32'h1);
    c.immSel = 3'd1; go(c);
    chk("R7", "S immediate", busValue, 32'hFFFFFDBA);
    chk("R9", "busy fell after 2", 32'(memBusy), 32'h0);
    c.immSel = 3'd2; go(c);
    chk("R7", "B immediate", busValue, 32'hFFFFF5BA);
    c.immSel = 3'd3; go(c);
    chk("R7", "U immediate", busValue, 32'hDAA66000);
    c.immSel = 3'd4; go(c);
    chk("R7", "J immediate", busValue, 32'hFFF665AA);
    c.immSel = 3'd6; go(c);
    chk("R7", "unused format", busValue, 32'h0);

    // Registers: rd=26, rs1=12, rs2=10, A=8
    go(regWrC(4'd9, 3'd0));
    go(regRdC(3'd0));
    chk("R4", "rd entry", busValue, 32'h8);
    go(regWrC(4'd10, 3'd1));
    go(regRdC(3'd1));
    chk("R4", "rs1 entry", busValue, 32'hC);
    go(regRdC(3'd0));
    chk("R4", "rd kept", busValue, 32'h8);
    c = regWrC(4'd9, 3'd2); c.regEn = 0; go(c);
    go(regRdC(3'd2));
    chk("R3", "write without enable ignored", busValue, 32'h0);
    go(regWrC(4'd10, 3'd3));
    go(regRdC(3'd3));
    chk("R4", "pc entry", busValue, 32'hC);
    go(regWrC(4'd9, 3'd4));
    go(regRdC(3'd4));
    chk("R4", "return address entry", busValue, 32'h8);
    c = regRdC(3'd3); c.regEn = 0; go(c);
    chk("R3", "read without enable", busValue, 32'h0);

    // Memory writes at MA=12
    c = aluC(4'd9); c.memEn = 1; c.memWr = 1; go(c);
    c = aluC(4'd10); c.memEn = 1; c.memWr = 1; go(c);
    chk("R9", "busy after write", 32'(memBusy), 32'h1);
    go(idleC());
    c = aluC(4'd10); c.memWr = 1; go(c);
    chk("R9", "busy low again", 32'(memBusy), 32'h0);
    go(memRdC());
    chk("R10", "only first write committed", busValue, 32'h8);

    // Entry 0 via IR=0 from word 0
    c = idleC(); c.ldMa = 1; go(c);
    go(idleC());
    c = memRdC(); c.ldIr = 1; go(c);
    chk("R8", "word 0 fill", busValue, 32'h0);
    go(regWrC(4'd9, 3'd0));
    chk("R11", "opcode zero", 32'(opcode), 32'h0);
    go(regRdC(3'd0));
    chk("R3", "entry 0 reads zero", busValue, 32'h0);

    // Operands: A=word 2, B=word 1
    c = idleC(); c.ldA = 1; go(c);
    c = aluC(4'd10); c.ldMa = 1; c.ldA = 1; go(c);
    c = memRdC(); c.ldB = 1; go(c);
    chk("R8", "word 1 fill", busValue, 32'h9E3779B1);
    c = aluC(4'd10); c.ldMa = 1; go(c);
    go(idleC());
    c = memRdC(); c.ldA = 1; go(c);
    chk("R8", "word 2 fill", busValue, 32'h3C6EF362);

    for (int i = 0; i < NROW; i++) begin
      c = aluC(TBL[i].op); c.ldA = TBL[i].ldA; c.ldB = TBL[i].ldB; go(c);
      chk("R5", $sformatf("row %0d result", i), busValue, TBL[i].bus);
      chk("R6", $sformatf("row %0d zero", i), 32'(zero), 32'(TBL[i].z));
    end

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule